// File: doc/BRIEF.md
# Oversampling ADC Scan Sequencer

This block runs an eight-input, 12-bit serial ADC through one complete scan each time it is started. For every input it collects sixteen conversions, adds them together and writes a single 14-bit oversampled value into a small RAM. The RAM address of each value is the number of the input it came from. The block contains three parts: the serial frame engine, the scan and burst controller, and the accumulator. The ADC and the RAM are outside the block.

The converter link is pipelined. The input number shifted out during one frame chooses what the converter samples in the following frame. A scan therefore begins with one priming frame whose returned data is thrown away. The serial clock is the system clock gated by the frame enable, and the chip select is the inverse of that enable. One idle cycle separates consecutive frames.

Top module: `adc_scan_sequencer`

## Requirements
- R1: While reset is asserted and right after it, `adc_csn_o` is 1, `adc_sclk_o`, `adc_mosi_o` and `wr_en_o` are 0, and `wr_data_o` is 0 (the accumulator is clear).
- R2: A `start_i` pulse seen while idle starts a scan of 8 × 16 + 1 = 129 frames. In every frame `adc_csn_o` stays low for exactly 16 clock cycles, and `adc_sclk_o` gives exactly 16 rising edges, each one at a system clock rising edge. `adc_csn_o` goes high for at least one cycle between frames.
- R3: `adc_sclk_o` never rises while `adc_csn_o` is high, so the converter sees no clock edges between frames or while idle.
- R4: Frame bits are counted from 0 in transmission order. The 3-bit input number is sent MSB first at bits 2, 3 and 4, and every other bit of the frame is 0. `adc_mosi_o` changes only while `clk` is low, and it is 0 whenever `adc_csn_o` is high.
- R5: The number sent in frame f (f = 0..127 within a scan) is f/16. The converter data of frame f+1 therefore belongs to input f/16, and the data of frame 0 is discarded. The next number is latched into the shifter at bit 14 of the frame before the one that sends it.
- R6: Each frame is read MSB first on rising clock edges, and only its low 12 bits are the sample. The upper 4 bits have no effect on the stored result.
- R7: For each input, the 16 samples are summed into a 16-bit accumulator. The accumulator restarts from zero at the start of each input's burst, so no earlier sum carries over.
- R8: The stored word is {2'b00, acc[15:2]}. For example, sixteen samples of 0xFFF store 16380.
- R9: Each scan gives exactly 8 writes, to addresses 0, 1, …, 7 in that order. Each `wr_en_o` pulse lasts one cycle.
- R10: A `start_i` that arrives during a scan is ignored: the scan still has 129 frames and 8 writes. After the write for input 7 the block stays idle, with `adc_csn_o` high, until the next start.
- R11: Asserting reset in the middle of a scan stops it at once. The next scan after reset produces correct results from a clear accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the source of the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin a scan |
| adc_miso_i | input | 1 | Serial data from the converter |
| adc_sclk_o | output | 1 | Gated serial clock to the converter |
| adc_csn_o | output | 1 | Active-low converter chip select |
| adc_mosi_o | output | 1 | Serial input-number bits to the converter |
| wr_en_o | output | 1 | One-cycle RAM write strobe |
| wr_addr_o | output | 3 | RAM write address (input number) |
| wr_data_o | output | 16 | Oversampled 14-bit result, zero-padded to 16 bits |

## Verification
The checks assume that the converter changes its data bit only on falling serial clock edges, so each bit is stable at the rising edge that samples it. The behavioural converter model in the bench does exactly this. The checks also assume that `start_i` is a clean pulse driven away from the clock edge. The bench drives it, and reset, on falling edges. The model returns samples that depend on the input number it decoded in the previous frame, so a wrong address sequence would show up as wrong stored sums. Some runs set the upper frame bits to nonzero noise, and others use all-ones samples to drive the accumulator to its maximum.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter #(
  parameter int FRAME_BITS = 16,
  parameter int CH_W       = 3,
  parameter int ADDR_POS   = 2,
  parameter int LOAD_BIT   = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_en_i,
  input  logic [CH_W-1:0]       tx_ch_i,
  input  logic                  miso_i,
  output logic                  sclk_o,
  output logic                  csn_o,
  output logic                  mosi_o,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  done_o
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] LOAD_CNT = CNT_W'(LOAD_BIT);

  logic [CNT_W-1:0]      bit_cnt_q, bit_cnt_d;
  logic [FRAME_BITS-1:0] shreg_q, shreg_d;
  logic [CH_W-1:0]       tx_ch_q, tx_ch_d;
  logic                  en_lat_q;
  logic                  mosi_q, mosi_d;

  // frame bit counter and receive shift register (rising edge)
  always_comb begin
    bit_cnt_d = '0;
    shreg_d   = shreg_q;
    tx_ch_d   = tx_ch_q;
    if (shift_en_i) begin
      bit_cnt_d = bit_cnt_q + 1'b1;
      shreg_d   = {shreg_q[FRAME_BITS-2:0], miso_i};
      if (bit_cnt_q == LOAD_CNT) begin
        tx_ch_d = tx_ch_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      tx_ch_q   <= '0;
    end else begin
      bit_cnt_q <= bit_cnt_d;
      shreg_q   <= shreg_d;
      tx_ch_q   <= tx_ch_d;
    end
  end

  // outgoing bit: channel number MSB first at ADDR_POS.., zero elsewhere
  always_comb begin
    mosi_d = 1'b0;
    for (int i = 0; i < CH_W; i++) begin
      if (shift_en_i && (bit_cnt_q == CNT_W'(ADDR_POS + i))) begin
        mosi_d = tx_ch_q[CH_W-1-i];
      end
    end
  end

  // falling-edge stage: outgoing bit and clock-gate enable
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mosi_q   <= 1'b0;
      en_lat_q <= 1'b0;
    end else begin
      mosi_q   <= mosi_d;
      en_lat_q <= shift_en_i;
    end
  end

  assign sclk_o  = clk & en_lat_q;
  assign csn_o   = ~shift_en_i;
  assign mosi_o  = mosi_q;
  assign frame_o = shreg_q;
  assign done_o  = shift_en_i && (bit_cnt_q == LAST_CNT);
endmodule

// File: rtl/adc_burst_ctrl.sv
module adc_burst_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_NUM = 8,
  parameter int BURST  = 16,
  parameter int CH_W   = $clog2(CH_NUM)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            done_i,
  output logic            shift_en_o,
  output logic [CH_W-1:0] tx_ch_o,
  output logic            acc_en_o,
  output logic            acc_first_o,
  output logic            wr_en_o,
  output logic [CH_W-1:0] wr_addr_o
);
  localparam int BURST_W = $clog2(BURST);
  localparam int NFRAMES = CH_NUM * BURST + 1;
  localparam int FRM_W   = $clog2(NFRAMES + 1);
  localparam logic [FRM_W-1:0]   LAST_FRM  = FRM_W'(NFRAMES - 1);
  localparam logic [BURST_W-1:0] LAST_SMP  = BURST_W'(BURST - 1);

  seq_state_e       state_q, state_d;
  logic [FRM_W-1:0] frm_q, frm_d;
  logic [FRM_W-1:0] frm_inc, smp_idx;
  logic             burst_last, wr_fire;
  logic             wr_en_q;
  logic [CH_W-1:0]  wr_addr_q, wr_addr_d;

  assign frm_inc = frm_q + 1'b1;
  assign smp_idx = frm_q - 1'b1;

  // next-state logic
  always_comb begin
    state_d = state_q;
    frm_d   = frm_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SHIFT;
          frm_d   = '0;
        end
      end
      ST_SHIFT: begin
        if (done_i) begin
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (frm_q == LAST_FRM) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_SHIFT;
          frm_d   = frm_inc;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frm_q   <= '0;
    end else begin
      state_q <= state_d;
      frm_q   <= frm_d;
    end
  end

  // datapath controls
  assign shift_en_o  = (state_q == ST_SHIFT);
  assign tx_ch_o     = CH_W'(frm_inc >> BURST_W);
  assign acc_en_o    = (state_q == ST_GAP) && (frm_q != '0);
  assign acc_first_o = (smp_idx[BURST_W-1:0] == '0);
  assign burst_last  = (smp_idx[BURST_W-1:0] == LAST_SMP);
  assign wr_fire     = acc_en_o && burst_last;

  always_comb begin
    wr_addr_d = wr_addr_q;
    if (wr_fire) begin
      wr_addr_d = CH_W'(smp_idx >> BURST_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
    end else begin
      wr_en_q   <= wr_fire;
      wr_addr_q <= wr_addr_d;
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
endmodule

// File: rtl/adc_sample_accum.sv
module adc_sample_accum #(
  parameter int FRAME_BITS  = 16,
  parameter int SAMPLE_BITS = 12,
  parameter int ACC_BITS    = 16,
  parameter int RES_BITS    = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_i,
  input  logic                  first_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  output logic [ACC_BITS-1:0]   result_o
);
  localparam int PAD_BITS = ACC_BITS - RES_BITS;

  logic [ACC_BITS-1:0] acc_q, acc_d, sample_ext;

  assign sample_ext = ACC_BITS'(frame_i[SAMPLE_BITS-1:0]);

  always_comb begin
    acc_d = acc_q;
    if (en_i) begin
      acc_d = first_i ? sample_ext : (acc_q + sample_ext);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign result_o = {{PAD_BITS{1'b0}}, acc_q[ACC_BITS-1 -: RES_BITS]};
endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer #(
  parameter int CH_NUM      = 8,
  parameter int BURST       = 16,
  parameter int FRAME_BITS  = 16,
  parameter int SAMPLE_BITS = 12,
  parameter int ACC_BITS    = 16,
  parameter int RES_BITS    = 14,
  parameter int ADDR_POS    = 2,
  parameter int LOAD_BIT    = 14,
  parameter int CH_W        = $clog2(CH_NUM)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                adc_miso_i,
  output logic                adc_sclk_o,
  output logic                adc_csn_o,
  output logic                adc_mosi_o,
  output logic                wr_en_o,
  output logic [CH_W-1:0]     wr_addr_o,
  output logic [ACC_BITS-1:0] wr_data_o
);
  logic                  rst_sync_q1, rst_sync_q2, rst_n_s;
  logic                  shift_en, done, acc_en, acc_first;
  logic [CH_W-1:0]       tx_ch;
  logic [FRAME_BITS-1:0] frame;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q1 <= 1'b0;
      rst_sync_q2 <= 1'b0;
    end else begin
      rst_sync_q1 <= 1'b1;
      rst_sync_q2 <= rst_sync_q1;
    end
  end
  assign rst_n_s = rst_sync_q2;

  adc_frame_shifter #(
    .FRAME_BITS(FRAME_BITS), .CH_W(CH_W), .ADDR_POS(ADDR_POS), .LOAD_BIT(LOAD_BIT)
  ) u_shifter (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .shift_en_i (shift_en),
    .tx_ch_i    (tx_ch),
    .miso_i     (adc_miso_i),
    .sclk_o     (adc_sclk_o),
    .csn_o      (adc_csn_o),
    .mosi_o     (adc_mosi_o),
    .frame_o    (frame),
    .done_o     (done)
  );

  adc_burst_ctrl #(
    .CH_NUM(CH_NUM), .BURST(BURST), .CH_W(CH_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (start_i),
    .done_i      (done),
    .shift_en_o  (shift_en),
    .tx_ch_o     (tx_ch),
    .acc_en_o    (acc_en),
    .acc_first_o (acc_first),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o)
  );

  adc_sample_accum #(
    .FRAME_BITS(FRAME_BITS), .SAMPLE_BITS(SAMPLE_BITS),
    .ACC_BITS(ACC_BITS), .RES_BITS(RES_BITS)
  ) u_accum (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .en_i     (acc_en),
    .first_i  (acc_first),
    .frame_i  (frame),
    .result_o (wr_data_o)
  );
endmodule

// File: rtl/adc_scan_sequencer_chk.sv
module adc_scan_sequencer_chk #(
  parameter int FRAME_BITS = 16,
  parameter int ADDR_POS   = 2,
  parameter int CH_W       = 3,
  parameter int ACC_BITS   = 16,
  parameter int RES_BITS   = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                adc_csn_o,
  input logic                adc_mosi_o,
  input logic                wr_en_o,
  input logic [CH_W-1:0]     wr_addr_o,
  input logic [ACC_BITS-1:0] wr_data_o
);
  logic [7:0]      low_cnt;
  logic [CH_W-1:0] last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      last_addr <= '0;
    end else begin
      low_cnt <= adc_csn_o ? 8'd0 : (low_cnt + 8'd1);
      if (wr_en_o) last_addr <= wr_addr_o;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (adc_csn_o && !wr_en_o && !adc_mosi_o));

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_csn_o) |-> (low_cnt == 8'(FRAME_BITS)));

  // R4
  mosi_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_csn_o |-> !adc_mosi_o);

  // R4
  mosi_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_csn_o && ((low_cnt < 8'(ADDR_POS)) || (low_cnt >= 8'(ADDR_POS + CH_W))))
      |-> !adc_mosi_o);

  // R9
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

  // R9
  wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && (wr_addr_o != '0)) |-> (wr_addr_o == last_addr + 1'b1));

  // R8
  wr_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_data_o[ACC_BITS-1 -: (ACC_BITS-RES_BITS)] == '0));
endmodule

bind adc_scan_sequencer adc_scan_sequencer_chk #(
  .FRAME_BITS(FRAME_BITS), .ADDR_POS(ADDR_POS), .CH_W(CH_W),
  .ACC_BITS(ACC_BITS), .RES_BITS(RES_BITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .adc_csn_o (adc_csn_o),
  .adc_mosi_o(adc_mosi_o),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o)
);

// File: tb/adc_scan_sequencer_bench.sv
`timescale 1ns/1ps
module adc_scan_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        miso = 1'b0;
  logic        sclk, csn, mosi, wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  adc_scan_sequencer u_adc_scan_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .adc_miso_i(miso),
    .adc_sclk_o(sclk), .adc_csn_o(csn), .adc_mosi_o(mosi),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  // stimulus vectors: {pattern[3:0], seed[11:0]}
  localparam logic [15:0] VEC [5] = '{16'h2000, 16'h0000, 16'h1000, 16'h3123, 16'h3A5F};

  int       cur_pat = 0;
  int       cur_seed = 0;
  logic [3:0] noise = 4'h0;

  function automatic logic [11:0] samp_fn(int pat, int seed, int ch, int k);
    case (pat)
      0:       return 12'hFFF;
      1:       return 12'h000;
      2:       return 12'((ch * 16 + k) * 13 + 7);
      default: return 12'(seed * (ch + 1) + k * k * 29 + ch);
    endcase
  endfunction

  function automatic int exp_res(int pat, int seed, int ch);
    int sum = 0;
    for (int k = 0; k < 16; k++) sum += samp_fn(pat, seed, ch, k);
    return sum >> 2;
  endfunction

  // ---- behavioural converter model ----
  logic [15:0] out_sr;
  logic [15:0] cap;
  int frames = 0;
  int rises = 0;
  int bad_len = 0;
  int bad_addr = 0;
  int bad_zero = 0;
  int oof_rises = 0;
  int prev_ch = 0;
  int mosi_phase_bad = 0;

  always @(negedge csn) begin
    logic [15:0] w;
    rises = 0;
    cap = '0;
    if (frames == 0) w = 16'h5A5A;
    else w = {noise, samp_fn(cur_pat, cur_seed, prev_ch, (frames - 1) % 16)};
    out_sr = w;
    miso <= w[15];
  end

  always @(negedge sclk) begin
    out_sr = {out_sr[14:0], 1'b0};
    miso <= out_sr[15];
  end

  always @(posedge sclk) begin
    if (csn) oof_rises++;
    rises++;
    cap = {cap[14:0], mosi};
  end

  always @(posedge csn) begin
    if (rst_n) begin
      if (rises != 16) bad_len++;
      if (int'(cap[13:11]) != ((frames / 16) % 8)) bad_addr++;
      if ((cap & 16'hC7FF) != 16'h0) bad_zero++;
      prev_ch = int'(cap[13:11]);
      frames++;
    end
  end

  always @(mosi) if (rst_n && clk) mosi_phase_bad++;

  // ---- write monitor ----
  int nwr = 0;
  int log_addr [16];
  int log_data [16];
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (nwr < 16) begin
        log_addr[nwr] = int'(wr_addr);
        log_data[nwr] = int'(wr_data);
      end
      nwr++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    frames = 0; bad_len = 0; bad_addr = 0; bad_zero = 0; oof_rises = 0; nwr = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000 && nwr < 8; i++) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic check_scan(input string tag);
    chk(nwr == 8, "R9", {tag, " write count"}, nwr, 8);
    chk(frames == 129, "R2", {tag, " frame count"}, frames, 129);
    chk(bad_len == 0, "R2", {tag, " frames without 16 sclk rises"}, bad_len, 0);
    chk(oof_rises == 0, "R3", {tag, " sclk rises outside frame"}, oof_rises, 0);
    chk(bad_addr == 0, "R5", {tag, " frames with wrong channel"}, bad_addr, 0);
    chk(bad_zero == 0, "R4", {tag, " frames with nonzero filler bits"}, bad_zero, 0);
    chk(mosi_phase_bad == 0, "R4", {tag, " mosi changes while clk high"}, mosi_phase_bad, 0);
    for (int c = 0; c < 8; c++) begin
      chk(log_addr[c] == c, "R9", {tag, " write address order"}, log_addr[c], c);
      chk(log_data[c] == exp_res(cur_pat, cur_seed, c), "R7",
          {tag, " stored sum (R6/R8)"}, log_data[c], exp_res(cur_pat, cur_seed, c));
    end
    chk(csn == 1'b1, "R10", {tag, " idle after channel 7"}, csn, 1);
  endtask

  // watchdog
  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL R2 watchdog expired: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(csn == 1'b1, "R1", "csn in reset", csn, 1);
    chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
    chk(mosi == 1'b0, "R1", "mosi in reset", mosi, 0);
    chk(wr_en == 1'b0, "R1", "wr_en in reset", wr_en, 0);
    chk(wr_data == 16'h0, "R1", "wr_data in reset", wr_data, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // idle: no start, no activity (R3)
    clear_model();
    repeat (60) @(negedge clk);
    chk(frames == 0, "R3", "frames while idle", frames, 0);
    chk(csn == 1'b1, "R3", "csn while idle", csn, 1);

    // vector table walk
    for (int v = 0; v < 5; v++) begin
      cur_pat  = int'(VEC[v][15:12]);
      cur_seed = int'(VEC[v][11:0]);
      noise    = (v % 2 == 1) ? 4'hB : 4'h0;  // R6 upper bits ignored
      clear_model();
      pulse_start();
      wait_done();
      check_scan($sformatf("vec%0d", v));
    end

    // R10: retrigger mid-scan is ignored
    cur_pat = 2; cur_seed = 0; noise = 4'h7;
    clear_model();
    pulse_start();
    repeat (500) @(negedge clk);
    pulse_start();
    wait_done();
    check_scan("retrigger");
    repeat (100) @(negedge clk);
    chk(frames == 129, "R10", "no restart after retrigger", frames, 129);

    // R11: reset mid-scan, then clean scan
    cur_pat = 0; noise = 4'h0;
    clear_model();
    pulse_start();
    repeat (700) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(csn == 1'b1, "R11", "csn after mid-scan reset", csn, 1);
    chk(wr_data == 16'h0, "R11", "accumulator cleared by reset", wr_data, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cur_pat = 3; cur_seed = 12'h2C1;
    clear_model();
    pulse_start();
    wait_done();
    check_scan("after_reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule